// File: doc/BRIEF.md
# Bitwise Logic Unit with Condition Flags

This block carries out one bitwise or sign-inversion operation per strobe on operands of byte, halfword-of-32 (word) or full 32-bit width. A size input picks the width; everything above the selected width is ignored on the way in and driven to zero on the way out. Alongside the result it produces five condition flags: carry, overflow, zero, sign and parity. It also drives a destination write-enable that tells the surrounding datapath whether the result is to be stored.

Each operation has its own flag rules. The pure logic operations clear carry and overflow. The compare-style TEST produces flags but suppresses the write. NOT writes its result and leaves every flag as it was. NEG reports a nonzero operand as carry and the most negative value as overflow. Result, write-enable and flags are registered: they appear on the clock edge that samples the strobe. When there is no strobe they hold, and the write-enable stays low.

Top module: `bitlogic_unit`

## Requirements
- R1: With `valid_i` high, the operation code selects the result, masked to the selected size: 0 = A AND B, 1 = A OR B, 2 = A XOR B, 3 = TEST (A AND B), 4 = NOT A, 5 = NEG A (two's complement). The result appears after the clock edge that samples the strobe.
- R2: For codes 0 to 3, carry and overflow are 0 after the operation.
- R3: TEST presents A AND B on `result_o` and updates the flags, but `wr_en_o` is 0. Codes 0, 1, 2, 4 and 5 drive `wr_en_o` to 1 for exactly the cycle after the strobe.
- R4: For every code except NOT, the zero flag is 1 exactly when the size-masked result is all zeros.
- R5: Size codes are 0 = 8 bits, 1 = 16 bits, 2 or 3 = 32 bits. For every code except NOT, the sign flag equals result bit 7, 15 or 31 respectively.
- R6: For every code except NOT, the parity flag is 1 when result bits 7..0 contain an even number of ones.
- R7: NOT leaves carry, overflow, zero, sign and parity unchanged.
- R8: For NEG, carry is 1 when the size-masked operand is nonzero, and overflow is 1 when it equals the most negative value of the size (0x80, 0x8000, 0x80000000).
- R9: Result bits above the selected size are 0, whatever A and B carry there.
- R10: Without a strobe, or with a reserved code 6 or 7, the result and flags hold and `wr_en_o` is 0.
- R11: After reset the result, the write-enable and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size select |
| a_i | input | 32 | Operand A (sole operand of NOT and NEG) |
| b_i | input | 32 | Operand B |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Destination write-enable |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag |
| zf_o | output | 1 | Zero flag |
| sf_o | output | 1 | Sign flag |
| pf_o | output | 1 | Parity flag |

## Verification
All state sits in one output register, so a wrong value shows up at the ports on the first edge after the strobe that caused it. The exception is a flag that NOT should have preserved. A corrupted flag of that kind stays hidden until the NOT has passed and is seen only by comparing against the earlier value, so the bench places NOT right after operations that leave distinctive flags. Size masking errors show as nonzero upper result bits or a sign flag taken from the wrong bit. The bench therefore drives operands with set upper bits at the byte and word sizes.

// File: rtl/lu_pkg.sv
package lu_pkg;

    typedef enum logic [2:0] {
        LU_AND  = 3'd0,
        LU_OR   = 3'd1,
        LU_XOR  = 3'd2,
        LU_TEST = 3'd3,
        LU_NOT  = 3'd4,
        LU_NEG  = 3'd5
    } lu_op_e;

    typedef struct packed {
        logic cf;
        logic of;
        logic zf;
        logic sf;
        logic pf;
    } lu_flags_t;

    function automatic logic lu_op_legal(input logic [2:0] op);
        return op <= 3'd5;
    endfunction

endpackage

// File: rtl/lu_compute.sv
module lu_compute #(
    parameter int DW  = 32,
    parameter int SZW = 2
) (
    input  logic [2:0]     op,
    input  logic [SZW-1:0] size,
    input  logic [DW-1:0]  a,
    input  logic [DW-1:0]  b,
    output logic [DW-1:0]  res,
    output logic [DW-1:0]  a_m
);
    import lu_pkg::*;

    localparam int NSEL = 1 << SZW;

    logic [DW-1:0] masks [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_mask
        localparam int W = ((8 << i) > DW) ? DW : (8 << i);
        assign masks[i] = {DW{1'b1}} >> (DW - W);
    end

    logic [DW-1:0] mask;
    logic [DW-1:0] raw;

    always_comb begin
        mask = masks[size];
        a_m  = a & mask;
        unique case (op)
            LU_AND, LU_TEST: raw = a & b;
            LU_OR:           raw = a | b;
            LU_XOR:          raw = a ^ b;
            LU_NOT:          raw = ~a;
            LU_NEG:          raw = -a;
            default:         raw = '0;
        endcase
        res = raw & mask;
    end

endmodule

// File: rtl/lu_flags.sv
module lu_flags #(
    parameter int DW  = 32,
    parameter int SZW = 2
) (
    input  logic [2:0]         op,
    input  logic [SZW-1:0]     size,
    input  logic [DW-1:0]      res,
    input  logic [DW-1:0]      a_m,
    output lu_pkg::lu_flags_t  flags
);
    import lu_pkg::*;

    localparam int NSEL = 1 << SZW;

    logic [DW-1:0] msbs [NSEL];

    for (genvar i = 0; i < NSEL; i++) begin : g_msb
        localparam int W = ((8 << i) > DW) ? DW : (8 << i);
        assign msbs[i] = {{(DW-1){1'b0}}, 1'b1} << (W - 1);
    end

    logic [DW-1:0] msb;

    always_comb begin
        msb      = msbs[size];
        flags.zf = (res == '0);
        flags.sf = |(res & msb);
        flags.pf = ~^res[7:0];
        if (op == LU_NEG) begin
            flags.cf = (a_m != '0);
            flags.of = (a_m == msb);
        end else begin
            flags.cf = 1'b0;
            flags.of = 1'b0;
        end
    end

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit #(
    parameter int DW  = 32,
    parameter int SZW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           valid_i,
    input  logic [2:0]     op_i,
    input  logic [SZW-1:0] size_i,
    input  logic [DW-1:0]  a_i,
    input  logic [DW-1:0]  b_i,
    output logic [DW-1:0]  result_o,
    output logic           wr_en_o,
    output logic           cf_o,
    output logic           of_o,
    output logic           zf_o,
    output logic           sf_o,
    output logic           pf_o
);
    import lu_pkg::*;

    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        lu_flags_t     fl;
    } state_t;

    state_t state_d, state_q;

    logic [DW-1:0] res_c;
    logic [DW-1:0] a_m_c;
    lu_flags_t     flags_c;

    lu_compute #(.DW(DW), .SZW(SZW)) u_compute (
        .op   (op_i),
        .size (size_i),
        .a    (a_i),
        .b    (b_i),
        .res  (res_c),
        .a_m  (a_m_c)
    );

    lu_flags #(.DW(DW), .SZW(SZW)) u_flags (
        .op    (op_i),
        .size  (size_i),
        .res   (res_c),
        .a_m   (a_m_c),
        .flags (flags_c)
    );

    always_comb begin
        state_d    = state_q;
        state_d.wr = 1'b0;
        if (valid_i && lu_op_legal(op_i)) begin
            state_d.res = res_c;
            state_d.wr  = (op_i != LU_TEST);
            if (op_i != LU_NOT) begin
                state_d.fl = flags_c;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.res;
    assign wr_en_o  = state_q.wr;
    assign cf_o     = state_q.fl.cf;
    assign of_o     = state_q.fl.of;
    assign zf_o     = state_q.fl.zf;
    assign sf_o     = state_q.fl.sf;
    assign pf_o     = state_q.fl.pf;

endmodule

// File: rtl/bitlogic_unit_chk.sv
module bitlogic_unit_chk #(
    parameter int DW  = 32,
    parameter int SZW = 2
) (
    input logic           clk,
    input logic           rst_n,
    input logic           valid_i,
    input logic [2:0]     op_i,
    input logic [SZW-1:0] size_i,
    input logic [DW-1:0]  a_i,
    input logic [DW-1:0]  result_o,
    input logic           wr_en_o,
    input logic           cf_o,
    input logic           of_o,
    input logic           zf_o,
    input logic           sf_o,
    input logic           pf_o
);

    // R2: the four logic codes leave carry and overflow clear
    p_logic_clears_cf_of_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd3) |=> (!cf_o && !of_o));

    // R3: TEST never raises the write-enable
    p_test_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd3) |=> !wr_en_o);

    // R4: zero flag agrees with the registered result
    p_zero_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd5 && op_i != 3'd4) |=> (zf_o == (result_o == '0)));

    // R7: NOT keeps every flag
    p_not_keeps_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd4) |=> $stable({cf_o, of_o, zf_o, sf_o, pf_o}));

    // R8: NEG of a zero operand gives no carry and a zero result
    p_neg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd5 && a_i == '0) |=> (!cf_o && zf_o));

    // R9: byte size clears all upper result bits
    p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i <= 3'd5 && size_i == '0) |=> (result_o[DW-1:8] == '0));

    // R10: no strobe means everything holds and no write
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i > 3'd5) |=>
            (!wr_en_o && $stable(result_o) && $stable({cf_o, of_o, zf_o, sf_o, pf_o})));

endmodule

bind bitlogic_unit bitlogic_unit_chk #(.DW(DW), .SZW(SZW)) u_chk (.*);

// File: tb/sim_bitlogic_unit.sv
module sim_bitlogic_unit;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic [4:0]  fl;   // cf, of, zf, sf, pf
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] result_o;
    logic        wr_en_o, cf_o, of_o, zf_o, sf_o, pf_o;

    int n_vec = 0;
    int n_bad = 0;
    exp_t q[$];

    // model state
    logic [31:0] m_res = '0;
    logic [4:0]  m_fl  = '0;

    always #2 clk = ~clk;

    bitlogic_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .cf_o(cf_o), .of_o(of_o), .zf_o(zf_o), .sf_o(sf_o), .pf_o(pf_o)
    );

    function automatic logic [31:0] size_mask(input logic [1:0] s);
        case (s)
            2'd0:    return 32'h0000_00FF;
            2'd1:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] size_msb(input logic [1:0] s);
        case (s)
            2'd0:    return 32'h0000_0080;
            2'd1:    return 32'h0000_8000;
            default: return 32'h8000_0000;
        endcase
    endfunction

    task automatic apply(input logic v, input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b, input string req);
        exp_t e;
        logic [31:0] m, r, am;
        int ones;
        @(negedge clk);
        valid_i = v; op_i = op; size_i = sz; a_i = a; b_i = b;
        m  = size_mask(sz);
        am = a & m;
        e.wr = 1'b0;
        if (v && op <= 3'd5) begin
            case (op)
                3'd0, 3'd3: r = a & b;
                3'd1:       r = a | b;
                3'd2:       r = a ^ b;
                3'd4:       r = ~a;
                default:    r = (~a) + 32'd1;
            endcase
            r = r & m;
            m_res = r;
            e.wr = (op != 3'd3);
            if (op != 3'd4) begin
                ones = 0;
                for (int i = 0; i < 8; i++) ones += int'(r[i]);
                m_fl[4] = (op == 3'd5) ? (am != 0) : 1'b0;
                m_fl[3] = (op == 3'd5) ? (am == size_msb(sz)) : 1'b0;
                m_fl[2] = (r == 0);
                m_fl[1] = ((r & size_msb(sz)) != 0);
                m_fl[0] = (ones % 2 == 0);
            end
        end
        e.res = m_res;
        e.fl  = m_fl;
        e.req = req;
        @(posedge clk);
        #1;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (result_o !== e.res || wr_en_o !== e.wr ||
                    {cf_o, of_o, zf_o, sf_o, pf_o} !== e.fl) begin
                    n_bad++;
                    $display("FAIL %s: got res=%h wr=%b fl=%b, expected res=%h wr=%b fl=%b",
                             e.req, result_o, wr_en_o, {cf_o, of_o, zf_o, sf_o, pf_o},
                             e.res, e.wr, e.fl);
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        n_vec++;
        if (result_o !== '0 || wr_en_o !== 1'b0 || {cf_o, of_o, zf_o, sf_o, pf_o} !== 5'b0) begin
            n_bad++;
            $display("FAIL R11: got res=%h wr=%b fl=%b, expected all zero",
                     result_o, wr_en_o, {cf_o, of_o, zf_o, sf_o, pf_o});
        end
        rst_n = 1'b1;

        // R1 R9: AND at byte size masks upper bits
        apply(1, 3'd0, 2'd0, 32'hFFFF_FF35, 32'hFFFF_FF0F, "R1 R9 and byte");
        // R5 R6: OR at word size, sign from bit 15
        apply(1, 3'd1, 2'd1, 32'h1234_8001, 32'h0000_0010, "R1 R5 R6 or word");
        // R7: NOT keeps the flags just produced
        apply(1, 3'd4, 2'd1, 32'h0000_00FF, 32'h0, "R7 not word");
        // R2 R4: XOR of equal dwords gives zero
        apply(1, 3'd2, 2'd2, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R2 R4 xor dword");
        // R8: NEG of most negative byte
        apply(1, 3'd5, 2'd0, 32'hABCD_EF80, 32'h0, "R8 neg byte min");
        // R7: NOT after NEG keeps carry and overflow
        apply(1, 3'd4, 2'd0, 32'h0000_000F, 32'h0, "R7 not after neg");
        // R2 R3: TEST clears cf/of, no write
        apply(1, 3'd3, 2'd2, 32'h8000_0001, 32'h8000_0000, "R2 R3 test dword");
        // R10 idle cycles hold
        apply(0, 3'd0, 2'd0, 32'h0, 32'h0, "R10 idle");
        apply(0, 3'd1, 2'd2, 32'hFFFF_FFFF, 32'h1, "R10 idle busy inputs");
        // R10 reserved codes
        apply(1, 3'd6, 2'd2, 32'h1, 32'h1, "R10 code 6");
        apply(1, 3'd7, 2'd0, 32'h1, 32'h1, "R10 code 7");
        // R8: NEG of zero
        apply(1, 3'd5, 2'd1, 32'hFFFF_0000, 32'h0, "R8 neg zero");
        // R8 R5: NEG of one at word size
        apply(1, 3'd5, 2'd1, 32'h0000_0001, 32'h0, "R8 R5 neg word one");
        // R8: NEG dword most negative, size code 3
        apply(1, 3'd5, 2'd3, 32'h8000_0000, 32'h0, "R5 R8 neg size3 min");
        // R3: TEST with zero result
        apply(1, 3'd3, 2'd0, 32'h0000_00F0, 32'h0000_000F, "R3 R4 test zero");
        // R1 R6: XOR byte odd parity
        apply(1, 3'd2, 2'd0, 32'h0000_0007, 32'h0000_0000, "R1 R6 xor byte odd");
        // R1: NOT dword
        apply(1, 3'd4, 2'd2, 32'h0F0F_0000, 32'h0, "R1 not dword");
        // R9: OR byte with upper ones
        apply(1, 3'd1, 2'd0, 32'hFF00_0000, 32'h00FF_0001, "R9 or byte upper");
        // R1: back-to-back AND word
        apply(1, 3'd0, 2'd1, 32'hF0F0_FFFF, 32'h0000_8181, "R1 and word");
        apply(0, 3'd0, 2'd0, 32'h0, 32'h0, "R10 final idle");

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule